// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the programming engine for a small on-chip code flash in parallel mode. An external programmer sets a four-pin operation code, an address and a data byte. It then pulses an active-low program strobe. The block decodes the operation and handles each kind as follows:

- Byte writes and lock-bit programming run as self-timed operations against a register-file model of the array.
- A chip erase is accepted only when the strobe is held low long enough.
- Code, verify and signature reads are served on a registered data output.

Progress is reported in two ways. A ready/busy line is low for the whole of a program or erase operation. While a byte write is running, a read of the byte being written returns the inverse of the written bit 7 on data bit 7; the other bits show the cell's current (still blank) content. The array and the three protection bits are not cleared by reset, because they model non-volatile storage. A chip erase is what sets them to a known state.

Write and erase durations are parameters in clock cycles. So is the input stability window that must pass before a strobe. Simulation can therefore use short values.

Top module: `flash_prog_seq`

## Requirements
- R1: The operation code is `mode_sel` = {bit3, bit2, bit1, bit0}: 0111 byte write, 0011 code read, 1111 protect level 1, 1100 protect level 2, 1010 protect level 3, 1000 chip erase, 0000 signature read. Any other code is a no-op, and a read under it returns FFh one cycle later.
- R2: A strobe falling edge that is sampled at a clock edge under byte write makes `rdy` low from that edge for exactly WRITE_CYC cycles. The byte is stored as `rdy` returns high, and a later code read returns it.
- R3: While a byte write is busy, a code read of its address returns {~written bit 7, stored bits 6:0}. A code read of any other address returns true data. After completion the same address returns the written byte.
- R4: A chip erase with the strobe held low for more than ERASE_CYC cycles keeps `rdy` low for ERASE_CYC + 2^ADDR_W cycles. Afterwards every byte reads FFh and `lock_state` is 000.
- R5: A chip erase strobe released before ERASE_CYC cycles elapse leaves the array unchanged, sets `wr_err` and returns `rdy` high.
- R6: A byte write whose target does not read FFh is refused. `rdy` stays high, `wr_err` is set and the byte keeps its value. Any later accepted program or erase command clears `wr_err`.
- R7: Strobes that arrive while `rdy` is low are ignored: they write nothing and do not change `wr_err`.
- R8: A program, protect or erase strobe is accepted only if `addr`, `din` and `mode_sel` have been unchanged for at least SETUP_CYC cycles. Otherwise it is refused with `wr_err` set and nothing written.
- R9: Signature reads return 1Eh at address 030h, 51h at 031h, and FFh (HIGH_VOLT=1) or 05h (HIGH_VOLT=0) at 032h. Every other address returns FFh.
- R10: Protect commands set `lock_state` bit 0, 1 or 2 for levels 1, 2 and 3. Level 1 makes every byte write refused as in R6. Level 2 makes code reads return 00h. Signature reads are unaffected.
- R11: During and right after reset, `rdy` is 1, `wr_err` is 0 and `dout` is FFh.
- R12: With `prog_en` low, strobes start nothing and `dout` reads FFh one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming interface enable |
| mode_sel | input | 4 | Operation code pins |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to write |
| prog_n | input | 1 | Active-low program strobe |
| dout | output | 8 | Registered read data |
| rdy | output | 1 | High when ready, low when busy |
| wr_err | output | 1 | Last program command was refused or aborted |
| lock_state | output | 3 | Programmed protection levels |

## Verification
A controller stuck in a busy state shows up at once as `rdy` held low past the expected count. An off-by-one in the write or erase timer shifts the measured busy length by a cycle on every operation. A wrong latched address or data byte surfaces on the read-back sweep over every location, and a bad polling compare shows on the first mid-write read. A blank check or stability counter that is wrong lets a refused write through; this becomes visible on the next read of that byte, within two cycles of the refusal.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_READ, OP_PROT1, OP_PROT2, OP_PROT3, OP_ERASE, OP_SIG
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_PROT, ST_HOLD, ST_SWEEP
  } st_e;

  // Pin order {bit3, bit2, bit1, bit0} is fixed by the programmer's wiring.
  function automatic op_e decode_sel(input logic [3:0] sel);
    case (sel)
      4'b0111: return OP_WRITE;
      4'b0011: return OP_READ;
      4'b1111: return OP_PROT1;
      4'b1100: return OP_PROT2;
      4'b1010: return OP_PROT3;
      4'b1000: return OP_ERASE;
      4'b0000: return OP_SIG;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [2:0] prot_mask(input op_e op);
    case (op)
      OP_PROT1: return 3'b001;
      OP_PROT2: return 3'b010;
      OP_PROT3: return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/fps_decode.sv
module fps_decode
  import fps_pkg::*;
(
  input  logic       en,
  input  logic [3:0] sel,
  output op_e        op
);
  always_comb begin
    op = en ? decode_sel(sel) : OP_NONE;
  end
endmodule

// File: rtl/fps_setup_mon.sv
module fps_setup_mon #(
  parameter int ADDR_W    = 12,
  parameter int SETUP_CYC = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [3:0]        sel,
  output logic              stable_ok
);
  localparam int SNAP_W = ADDR_W + 12;
  localparam int CW     = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(SETUP_CYC);

  logic [SNAP_W-1:0] snap_q, snap_now;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              changed;

  always_comb begin
    snap_now = {addr, din, sel};
    changed  = (snap_now != snap_q);
    if (changed)                cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;
    stable_ok = !changed && (cnt_q == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      cnt_q  <= '0;
    end else begin
      snap_q <= snap_now;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/fps_array.sv
module fps_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Non-volatile cell model: no reset, contents set only by writes and erase.
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 36000,
  parameter int ERASE_CYC = 240000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              stable_ok,
  input  logic              cell_blank,
  output logic              rdy,
  output logic              err,
  output logic [2:0]        locks,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              poll_active,
  output logic [ADDR_W-1:0] poll_addr,
  output logic              poll_bit
);
  localparam int CNT_MAX = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WR_LD = CW'(WRITE_CYC - 1);
  localparam logic [CW-1:0] ER_LD = CW'(ERASE_CYC - 1);

  st_e               st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [7:0]        lat_data_q;
  logic [2:0]        lat_mask_q;
  logic [2:0]        lock_q;
  logic              prog_q, err_q, err_d;
  logic              fall, is_prog, lat_ld, lock_set, lock_clr;

  always_comb begin
    fall    = prog_q && !prog_n;
    is_prog = (op == OP_WRITE) || (op == OP_ERASE) ||
              (op == OP_PROT1) || (op == OP_PROT2) || (op == OP_PROT3);
    st_d     = st_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    err_d    = err_q;
    lat_ld   = 1'b0;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    mem_we   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall && is_prog) begin
          if (!stable_ok) begin
            err_d = 1'b1;
          end else if (op == OP_WRITE) begin
            if (lock_q[0] || !cell_blank) begin
              err_d = 1'b1;
            end else begin
              st_d   = ST_WRITE;
              cnt_d  = WR_LD;
              err_d  = 1'b0;
              lat_ld = 1'b1;
            end
          end else if (op == OP_ERASE) begin
            st_d  = ST_HOLD;
            cnt_d = ER_LD;
            err_d = 1'b0;
          end else begin
            st_d   = ST_PROT;
            cnt_d  = WR_LD;
            err_d  = 1'b0;
            lat_ld = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (cnt_q == '0) begin
          mem_we = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PROT: begin
        if (cnt_q == '0) begin
          lock_set = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (prog_n) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else if (cnt_q == '0) begin
          lock_clr = 1'b1;
          ptr_d    = '0;
          st_d     = ST_SWEEP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SWEEP: begin
        mem_we = 1'b1;
        if (&ptr_q) st_d  = ST_IDLE;
        else        ptr_d = ptr_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
      prog_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
      prog_q <= prog_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lat_mask_q <= '0;
    end else if (lat_ld) begin
      lat_addr_q <= addr;
      lat_data_q <= din;
      lat_mask_q <= prot_mask(op);
    end
  end

  // Protection bits are non-volatile: only erase clears them.
  always_ff @(posedge clk) begin
    if (lock_clr)      lock_q <= '0;
    else if (lock_set) lock_q <= lock_q | lat_mask_q;
  end

  assign rdy         = (st_q == ST_IDLE);
  assign err         = err_q;
  assign locks       = lock_q;
  assign mem_waddr   = (st_q == ST_SWEEP) ? ptr_q : lat_addr_q;
  assign mem_wdata   = (st_q == ST_SWEEP) ? 8'hFF : lat_data_q;
  assign poll_active = (st_q == ST_WRITE);
  assign poll_addr   = lat_addr_q;
  assign poll_bit    = ~lat_data_q[7];
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 36000,
  parameter int ERASE_CYC = 240000,
  parameter int SETUP_CYC = 48,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              prog_n,
  output logic [7:0]        dout,
  output logic              rdy,
  output logic              wr_err,
  output logic [2:0]        lock_state
);
  localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(48);
  localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(49);
  localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(50);
  localparam logic [7:0]        SIG_V2 = HIGH_VOLT ? 8'hFF : 8'h05;

  op_e               op;
  logic              stable_ok, mem_we, poll_active, poll_bit, cell_blank;
  logic [ADDR_W-1:0] mem_waddr, poll_addr;
  logic [7:0]        mem_wdata, rdata, dout_d, dout_q;

  fps_decode u_dec (
    .en  (prog_en),
    .sel (mode_sel),
    .op  (op)
  );

  fps_setup_mon #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) u_setup (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .din       (din),
    .sel       (mode_sel),
    .stable_ok (stable_ok)
  );

  fps_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (addr),
    .rdata (rdata)
  );

  assign cell_blank = (rdata == 8'hFF);

  fps_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .prog_n      (prog_n),
    .addr        (addr),
    .din         (din),
    .stable_ok   (stable_ok),
    .cell_blank  (cell_blank),
    .rdy         (rdy),
    .err         (wr_err),
    .locks       (lock_state),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .poll_active (poll_active),
    .poll_addr   (poll_addr),
    .poll_bit    (poll_bit)
  );

  always_comb begin
    dout_d = 8'hFF;
    if (op == OP_READ) begin
      if (lock_state[1])                          dout_d = 8'h00;
      else if (poll_active && addr == poll_addr)  dout_d = {poll_bit, rdata[6:0]};
      else                                        dout_d = rdata;
    end else if (op == OP_SIG) begin
      if (addr == SIG_A0)      dout_d = 8'h1E;
      else if (addr == SIG_A1) dout_d = 8'h51;
      else if (addr == SIG_A2) dout_d = SIG_V2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 8'hFF;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_en,
  input logic       prog_n,
  input logic       rdy,
  input logic       wr_err,
  input logic       mem_we,
  input logic       stable_ok,
  input logic [7:0] dout
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R6
  refuse_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(wr_err) |-> rdy);

  // R2
  busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(rdy) |-> $past(!prog_n && prog_en));

  // R8
  busy_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(rdy) |-> $past(stable_ok));

  // R4
  write_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rdy);

  // R12
  disabled_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!prog_en) |-> dout == 8'hFF);
endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_en   (prog_en),
  .prog_n    (prog_n),
  .rdy       (rdy),
  .wr_err    (wr_err),
  .mem_we    (mem_we),
  .stable_ok (stable_ok),
  .dout      (dout)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WC     = 12;
  localparam int EC     = 10;
  localparam int SC     = 3;
  localparam logic [3:0] M_WR = 4'b0111, M_RD = 4'b0011, M_P1 = 4'b1111,
                         M_P2 = 4'b1100, M_P3 = 4'b1010, M_ER = 4'b1000,
                         M_SG = 4'b0000, M_BAD = 4'b0101;

  logic clk, rst_n, prog_en, prog_n, rdy, wr_err;
  logic [3:0] mode_sel;
  logic [ADDR_W-1:0] addr;
  logic [7:0] din, dout;
  logic [2:0] lock_state;
  int checks, failures;
  bit done;

  flash_prog_seq #(.ADDR_W(ADDR_W), .WRITE_CYC(WC), .ERASE_CYC(EC),
                   .SETUP_CYC(SC), .HIGH_VOLT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mode_sel(mode_sel),
    .addr(addr), .din(din), .prog_n(prog_n), .dout(dout), .rdy(rdy),
    .wr_err(wr_err), .lock_state(lock_state));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input int a, input logic [7:0] d);
    @(negedge clk);
    mode_sel = s; addr = ADDR_W'(a); din = d;
  endtask

  task automatic settle();
    repeat (SC + 2) @(negedge clk);
  endtask

  task automatic strobe(output int busy);
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    busy = 0;
    while (!rdy && busy < 100000) begin busy++; @(negedge clk); end
  endtask

  task automatic do_cmd(input logic [3:0] s, input int a, input logic [7:0] d, output int busy);
    drive(s, a, d); settle(); strobe(busy);
  endtask

  task automatic rd(input logic [3:0] s, input int a, output logic [7:0] v);
    drive(s, a, 8'h00);
    @(negedge clk);
    v = dout;
  endtask

  task automatic do_erase(output int busy);
    drive(M_ER, 0, 8'h00); settle();
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk);
    busy = 0;
    while (!rdy && busy < 100000) begin
      if (busy == EC + 1) prog_n = 1'b1;
      busy++;
      @(negedge clk);
    end
    prog_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL all watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busy;
    logic [7:0] v;
    checks = 0; failures = 0; done = 0;
    rst_n = 0; prog_n = 1; prog_en = 0; mode_sel = 4'b0000; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R11 rdy in reset", rdy, 1);
    check("R11 err in reset", wr_err, 0);
    check("R11 dout in reset", dout, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    check("R11 rdy after reset", rdy, 1);
    check("R11 dout after reset", dout, 8'hFF);

    // R12: disabled interface
    rd(M_SG, 48, v);
    check("R12 disabled read", v, 8'hFF);
    prog_en = 1;

    // R4: full erase and its duration
    do_erase(busy);
    check("R4 erase busy length", busy, EC + DEPTH);
    check("R4 locks cleared", lock_state, 3'b000);
    for (int a = 0; a < DEPTH; a++) begin
      rd(M_RD, a, v);
      check("R4 blank after erase", v, 8'hFF);
    end

    // R8: strobe too soon after input change is refused
    drive(M_WR, 5, 8'h3C);
    @(negedge clk);
    strobe(busy);
    check("R8 early strobe no busy", busy, 0);
    check("R8 early strobe err", wr_err, 1);
    rd(M_RD, 5, v);
    check("R8 early strobe no write", v, 8'hFF);

    // R12: strobe with interface disabled
    prog_en = 0;
    do_cmd(M_WR, 6, 8'h11, busy);
    check("R12 disabled strobe no busy", busy, 0);
    prog_en = 1;
    rd(M_RD, 6, v);
    check("R12 disabled strobe no write", v, 8'hFF);

    // R2: exhaustive write sweep with busy length
    for (int a = 0; a < DEPTH; a++) begin
      do_cmd(M_WR, a, pat(a), busy);
      check("R2 write busy length", busy, WC);
      if (a == 0) check("R6 err cleared by accepted write", wr_err, 0);
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(M_RD, a, v);
      check("R2 read back", v, pat(a));
    end

    // R6: rewrite of non-blank byte
    do_cmd(M_WR, 9, 8'h00, busy);
    check("R6 refused no busy", busy, 0);
    check("R6 refused err", wr_err, 1);
    rd(M_RD, 9, v);
    check("R6 byte unchanged", v, pat(9));

    // R5: aborted erase
    drive(M_ER, 0, 8'h00); settle();
    @(negedge clk); prog_n = 0;
    repeat (3) @(negedge clk);
    prog_n = 1;
    busy = 0;
    while (!rdy && busy < 1000) begin busy++; @(negedge clk); end
    check("R5 abort returns ready", rdy, 1);
    check("R5 abort err", wr_err, 1);
    rd(M_RD, 77, v);
    check("R5 array intact", v, pat(77));

    // R9: signature, including non-signature address
    rd(M_SG, 48, v); check("R9 sig 030", v, 8'h1E);
    rd(M_SG, 49, v); check("R9 sig 031", v, 8'h51);
    rd(M_SG, 50, v); check("R9 sig 032 low-volt", v, 8'h05);
    rd(M_SG, 51, v); check("R9 sig other", v, 8'hFF);
    // R1: undefined code
    rd(M_BAD, 3, v); check("R1 undefined code reads FF", v, 8'hFF);

    // R3 and R7: polling and busy ignore
    do_erase(busy);
    do_cmd(M_WR, 100, pat(100), busy);
    drive(M_WR, 64, 8'hA5); settle();
    @(negedge clk); prog_n = 0;
    @(negedge clk); prog_n = 1;
    mode_sel = M_RD;
    @(negedge clk);
    check("R3 poll inverted bit7", dout, 8'h7F);
    addr = 8'd100;
    @(negedge clk);
    check("R3 other addr true data", dout, pat(100));
    mode_sel = M_WR; addr = 8'd65; din = 8'h34;
    repeat (SC + 2) @(negedge clk);
    check("R7 still busy before ignored strobe", rdy, 0);
    prog_n = 0;
    @(negedge clk); prog_n = 1;
    busy = 0;
    while (!rdy && busy < 1000) begin busy++; @(negedge clk); end
    check("R7 err untouched", wr_err, 0);
    rd(M_RD, 64, v); check("R3 true data after write", v, 8'hA5);
    rd(M_RD, 65, v); check("R7 ignored strobe wrote nothing", v, 8'hFF);

    // R10: protection levels
    do_cmd(M_P1, 0, 8'h00, busy);
    check("R10 protect busy length", busy, WC);
    check("R10 level1 bit", lock_state, 3'b001);
    do_cmd(M_WR, 70, 8'h22, busy);
    check("R10 level1 refuses write", busy, 0);
    check("R10 level1 err", wr_err, 1);
    rd(M_RD, 70, v); check("R10 level1 byte blank", v, 8'hFF);
    do_cmd(M_P2, 0, 8'h00, busy);
    check("R10 level2 bit", lock_state, 3'b011);
    rd(M_RD, 64, v); check("R10 level2 read blocked", v, 8'h00);
    rd(M_SG, 49, v); check("R10 sig unaffected", v, 8'h51);
    do_cmd(M_P3, 0, 8'h00, busy);
    check("R10 level3 bit", lock_state, 3'b111);
    do_erase(busy);
    check("R4 erase clears locks", lock_state, 3'b000);
    rd(M_RD, 64, v); check("R4 erased after locks", v, 8'hFF);
    do_cmd(M_WR, 70, 8'h22, busy);
    check("R2 write after unlock", busy, WC);
    rd(M_RD, 70, v); check("R2 read after unlock", v, 8'h22);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule